// File: doc/BRIEF.md
# Interrupt Mask and Vector Unit

This block sits beside an instruction decoder and handles everything about interrupts except the bus work. Four hardware request lines come in: one non-maskable line and three maskable levels, named 5.5, 6.5 and 7.5 after their restart slots. A global enable flip-flop and three mask bits gate the maskable levels. A fixed-priority resolver picks one winner and presents a one-cycle acknowledge with a 16-bit restart address. The decoder drives single-cycle strobes for enable, disable, mask write, mask read, halt and software restart.

Mask writes and mask reads move one byte. That byte also carries a serial output bit and a serial input bit. A software restart number from 0 to 7 is turned into its own restart address on a separate output. A halt latch records the halt command and is released only by an accepted interrupt or by reset.

All outputs are registered. Reset is synchronous and active high.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the enable flip-flop is 0 and all three masks are 1 (masked). Serial out, both pending latches, `hw_ack`, `sw_vld`, `halted` and `rdata` are all 0.
- R2: `cmd_ei` sets the enable flip-flop and `cmd_di` clears it. Each takes effect at the next clock edge.
- R3: On `cmd_wmask` with data bit 3 set, bits 2, 1 and 0 load the masks of levels 7.5, 6.5 and 5.5, where 1 means masked. With bit 3 clear, the masks keep their values.
- R4: On `cmd_wmask` with data bit 6 set, `ser_out` takes data bit 7. With bit 6 clear, `ser_out` keeps its value.
- R5: On `cmd_rmask`, `rdata` is loaded at the next edge with {bit 7: `ser_in`, bit 6: 7.5 pending latch, bit 5: `req_l65`, bit 4: `req_l55`, bit 3: enable flip-flop, bits 2:0: masks 7.5/6.5/5.5}. The values captured are those before that edge's updates.
- R6: The hardware restart addresses are 0x0024 for non-maskable, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5.
- R7: Priority is non-maskable, then 7.5, then 6.5, then 5.5. At most one `hw_ack` pulse is issued per cycle. `hw_ack` and `hw_vec` appear at the edge where the winning request is eligible.
- R8: A maskable level is eligible only while the enable flip-flop is 1 and its mask is 0. The non-maskable line ignores both, and is latched on its rising edge, so a held-high line is acknowledged once.
- R9: A rising edge on `req_l75` sets a pending latch, even while masked or disabled. The latch holds until it is acknowledged or cleared by a mask write with data bit 4 set. Levels 6.5 and 5.5 are sensed as levels.
- R10: Accepting any interrupt clears the enable flip-flop at the same edge.
- R11: `cmd_swrst` with number n gives `sw_vld` = 1 and `sw_vec` = n*8 at the next edge.
- R12: `cmd_halt` sets `halted`. It stays set until an interrupt is accepted, which clears it at the acknowledge edge, or until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable request, rising-edge sensed |
| req_l75 | input | 1 | Level 7.5 request, rising-edge sensed |
| req_l65 | input | 1 | Level 6.5 request, level sensed |
| req_l55 | input | 1 | Level 5.5 request, level sensed |
| cmd_ei | input | 1 | Enable-interrupts strobe |
| cmd_di | input | 1 | Disable-interrupts strobe |
| cmd_wmask | input | 1 | Mask-write strobe |
| cmd_rmask | input | 1 | Mask-read strobe |
| cmd_halt | input | 1 | Halt strobe |
| cmd_swrst | input | 1 | Software restart strobe |
| swrst_num | input | 3 | Software restart number |
| wdata | input | 8 | Mask-write byte |
| ser_in | input | 1 | Serial input bit |
| rdata | output | 8 | Mask-read byte |
| ser_out | output | 1 | Serial output bit |
| hw_ack | output | 1 | One-cycle acknowledge of a hardware interrupt |
| hw_vec | output | 16 | Restart address of the acknowledged interrupt |
| sw_vld | output | 1 | Software restart address valid |
| sw_vec | output | 16 | Software restart address |
| halted | output | 1 | Halt latch |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, a slot step of 8 and a 3-bit restart number. This keeps the whole control space small enough to enumerate. It sweeps all eight mask settings against all eight combinations of the three maskable lines. For each case it predicts the winner and its address by arithmetic and checks the read-back byte. It also enumerates every software restart number. Directed sequences cover the remaining cases:
- a non-maskable edge while disabled;
- a simultaneous non-maskable and 7.5 edge, with 7.5 left pending;
- clearing the 7.5 latch by a mask write;
- the serial-output enable;
- halt release by an accepted interrupt and by reset.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int NSRC = 4;

  // source index doubles as priority rank: higher index wins
  typedef enum logic [1:0] {
    SRC_L55 = 2'd0,
    SRC_L65 = 2'd1,
    SRC_L75 = 2'd2,
    SRC_NMI = 2'd3
  } irq_src_e;

  // restart slot numbers; address = slot*step + step/2
  localparam int NMI_SLOT = 4;
  localparam int L55_SLOT = 5;

  // mask-write byte fields
  localparam int WB_SOD   = 7;
  localparam int WB_SOE   = 6;
  localparam int WB_CLR75 = 4;
  localparam int WB_MSE   = 3;

endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);

  logic [W-1:0] req_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[g] <= 1'b0;
        pend[g]  <= 1'b0;
      end else begin
        req_q[g] <= req[g];
        if (req[g] && !req_q[g])
          pend[g] <= 1'b1;
        else if (clr[g])
          pend[g] <= 1'b0;
      end
    end

    // a fresh rising edge always leaves the latch set
    assert_edge_sets_R9: assert property (@(posedge clk) disable iff (rst)
      (req[g] && !req_q[g]) |=> pend[g]);
  end

endmodule

// File: rtl/irqv_mask_regs.sv
module irqv_mask_regs
  import irqv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_ei,
  input  logic       cmd_di,
  input  logic       cmd_wmask,
  input  logic       cmd_rmask,
  input  logic [7:0] wdata,
  input  logic       accept,
  input  logic       ser_in,
  input  logic       pend_l75,
  input  logic       lvl_l65,
  input  logic       lvl_l55,
  output logic       ien,
  output logic [2:0] mask,
  output logic       ser_out,
  output logic       clr_l75,
  output logic [7:0] rdata
);

  logic wdata_unused;
  assign wdata_unused = wdata[5];

  assign clr_l75 = cmd_wmask && wdata[WB_CLR75];

  always_ff @(posedge clk) begin
    if (rst) begin
      ien     <= 1'b0;
      mask    <= 3'b111;
      ser_out <= 1'b0;
      rdata   <= 8'h00;
    end else begin
      if (accept)
        ien <= 1'b0;
      else if (cmd_di)
        ien <= 1'b0;
      else if (cmd_ei)
        ien <= 1'b1;

      if (cmd_wmask && wdata[WB_MSE])
        mask <= wdata[2:0];
      if (cmd_wmask && wdata[WB_SOE])
        ser_out <= wdata[WB_SOD];

      if (cmd_rmask)
        rdata <= {ser_in, pend_l75, lvl_l65, lvl_l55, ien, mask};
    end
  end

  assert_di_clears_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_di |=> !ien);

  assert_accept_drops_ien_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !ien);

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wmask && !wdata[WB_MSE]) |=> $stable(mask));

  assert_ser_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(cmd_wmask && wdata[WB_SOE])) |=> $stable(ser_out));

endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int RST_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien,
  input  logic [2:0]       mask,
  input  logic             pend_nmi,
  input  logic             pend_l75,
  input  logic             lvl_l65,
  input  logic             lvl_l55,
  output logic [NSRC-1:0]  grant,
  output logic             accept,
  output logic             hw_ack,
  output logic [VEC_W-1:0] hw_vec
);

  localparam int HALF = RST_STEP / 2;

  logic [NSRC-1:0]  hit;
  logic [VEC_W-1:0] vtab [NSRC];
  logic [VEC_W-1:0] vec_nxt;
  logic             taken;

  assign hit[SRC_NMI] = pend_nmi;
  assign hit[SRC_L75] = ien && !mask[2] && pend_l75;
  assign hit[SRC_L65] = ien && !mask[1] && lvl_l65;
  assign hit[SRC_L55] = ien && !mask[0] && lvl_l55;

  for (genvar g = 0; g < NSRC; g++) begin : g_vt
    localparam int SLOT = (g == NSRC - 1) ? NMI_SLOT : g + L55_SLOT;
    assign vtab[g] = VEC_W'(SLOT * RST_STEP + HALF);
  end

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    vec_nxt = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vec_nxt = vtab[i];
  end

  assign accept = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_ack <= 1'b0;
      hw_vec <= '0;
    end else begin
      hw_ack <= accept;
      if (accept)
        hw_vec <= vec_nxt;
    end
  end

  assert_nmi_first_R7: assert property (@(posedge clk) disable iff (rst)
    pend_nmi |=> (hw_ack && hw_vec == vtab[SRC_NMI]));

  assert_masked_level_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (!ien && !pend_nmi) |=> !hw_ack);

endmodule

// File: rtl/irqv_swrst.sv
module irqv_swrst #(
  parameter int VEC_W    = 16,
  parameter int RST_STEP = 8,
  parameter int NUM_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic [NUM_W-1:0] num,
  output logic             sw_vld,
  output logic [VEC_W-1:0] sw_vec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_vld <= 1'b0;
      sw_vec <= '0;
    end else begin
      sw_vld <= cmd;
      if (cmd)
        sw_vec <= VEC_W'(int'(num) * RST_STEP);
    end
  end

  assert_sw_vec_R11: assert property (@(posedge clk) disable iff (rst)
    cmd |=> (sw_vld && sw_vec == VEC_W'(int'($past(num)) * RST_STEP)));

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int RST_STEP = 8,
  parameter int NUM_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_nmi,
  input  logic             req_l75,
  input  logic             req_l65,
  input  logic             req_l55,
  input  logic             cmd_ei,
  input  logic             cmd_di,
  input  logic             cmd_wmask,
  input  logic             cmd_rmask,
  input  logic             cmd_halt,
  input  logic             cmd_swrst,
  input  logic [NUM_W-1:0] swrst_num,
  input  logic [7:0]       wdata,
  input  logic             ser_in,
  output logic [7:0]       rdata,
  output logic             ser_out,
  output logic             hw_ack,
  output logic [VEC_W-1:0] hw_vec,
  output logic             sw_vld,
  output logic [VEC_W-1:0] sw_vec,
  output logic             halted
);

  logic [NSRC-1:0] grant;
  logic            accept;
  logic            ien;
  logic [2:0]      mask;
  logic            clr_l75;
  logic [1:0]      pend;   // [1] non-maskable, [0] level 7.5

  irqv_edge_latch #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .req  ({req_nmi, req_l75}),
    .clr  ({grant[SRC_NMI], grant[SRC_L75] | clr_l75}),
    .pend (pend)
  );

  irqv_mask_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cmd_ei    (cmd_ei),
    .cmd_di    (cmd_di),
    .cmd_wmask (cmd_wmask),
    .cmd_rmask (cmd_rmask),
    .wdata     (wdata),
    .accept    (accept),
    .ser_in    (ser_in),
    .pend_l75  (pend[0]),
    .lvl_l65   (req_l65),
    .lvl_l55   (req_l55),
    .ien       (ien),
    .mask      (mask),
    .ser_out   (ser_out),
    .clr_l75   (clr_l75),
    .rdata     (rdata)
  );

  irqv_prio #(.VEC_W(VEC_W), .RST_STEP(RST_STEP)) u_prio (
    .clk      (clk),
    .rst      (rst),
    .ien      (ien),
    .mask     (mask),
    .pend_nmi (pend[1]),
    .pend_l75 (pend[0]),
    .lvl_l65  (req_l65),
    .lvl_l55  (req_l55),
    .grant    (grant),
    .accept   (accept),
    .hw_ack   (hw_ack),
    .hw_vec   (hw_vec)
  );

  irqv_swrst #(.VEC_W(VEC_W), .RST_STEP(RST_STEP), .NUM_W(NUM_W)) u_sw (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_swrst),
    .num    (swrst_num),
    .sw_vld (sw_vld),
    .sw_vec (sw_vec)
  );

  // halt latch: an accepted interrupt outranks a new halt strobe
  always_ff @(posedge clk) begin
    if (rst)
      halted <= 1'b0;
    else if (accept)
      halted <= 1'b0;
    else if (cmd_halt)
      halted <= 1'b1;
  end

  assert_ack_releases_halt_R12: assert property (@(posedge clk) disable iff (rst)
    hw_ack |-> !halted);

  assert_halt_sets_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_halt && !accept) |=> halted);

endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_nmi, req_l75, req_l65, req_l55;
  logic        cmd_ei, cmd_di, cmd_wmask, cmd_rmask, cmd_halt, cmd_swrst;
  logic [2:0]  swrst_num;
  logic [7:0]  wdata;
  logic        ser_in;
  logic [7:0]  rdata;
  logic        ser_out, hw_ack, sw_vld, halted;
  logic [15:0] hw_vec, sw_vec;

  int nchk  = 0;
  int nfail = 0;

  always #(CLK_P / 2) clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst(rst),
    .req_nmi(req_nmi), .req_l75(req_l75), .req_l65(req_l65), .req_l55(req_l55),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_wmask(cmd_wmask), .cmd_rmask(cmd_rmask),
    .cmd_halt(cmd_halt), .cmd_swrst(cmd_swrst), .swrst_num(swrst_num),
    .wdata(wdata), .ser_in(ser_in), .rdata(rdata), .ser_out(ser_out),
    .hw_ack(hw_ack), .hw_vec(hw_vec), .sw_vld(sw_vld), .sw_vec(sw_vec),
    .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmd_ei = 0; cmd_di = 0; cmd_wmask = 0; cmd_rmask = 0;
    cmd_halt = 0; cmd_swrst = 0;
  endtask

  task automatic wmask(input logic [7:0] d);
    cmd_wmask = 1; wdata = d;
    tick();
  endtask

  task automatic rmask_expect(input logic [7:0] exp, input string tag);
    cmd_rmask = 1;
    tick();
    chk(rdata == exp, tag, {8'h0, rdata}, {8'h0, exp});
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1;
    {req_nmi, req_l75, req_l65, req_l55} = '0;
    {cmd_ei, cmd_di, cmd_wmask, cmd_rmask, cmd_halt, cmd_swrst} = '0;
    swrst_num = '0; wdata = '0; ser_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(!hw_ack && !sw_vld && !halted && !ser_out && rdata == 8'h00, "R1 outputs",
        {8'h0, rdata}, 16'h0);
    rmask_expect(8'h07, "R1 read-back");

    // R2 enable and disable seen through the read byte
    cmd_ei = 1; tick();
    rmask_expect(8'h0F, "R2 enable");
    cmd_di = 1; tick();
    rmask_expect(8'h07, "R2 disable");

    // R3 R5 R6 R7 R8 R10: masks x maskable lines sweep
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 8; r++) begin
        logic [2:0]  msk;
        logic [2:0]  rq;
        int          k;
        logic [15:0] ev;
        msk = 3'(m); rq = 3'(r);
        {req_l75, req_l65, req_l55} = 3'b000;
        cmd_di = 1; wmask(8'h18 | {5'b0, msk});
        {req_l75, req_l65, req_l55} = rq;
        tick();
        cmd_ei = 1; tick();
        ser_in = msk[0] ^ rq[0];
        cmd_rmask = 1; tick();
        k = (rq[2] && !msk[2]) ? 7 : (rq[1] && !msk[1]) ? 6 :
            (rq[0] && !msk[0]) ? 5 : 0;
        ev = 16'(k * 8 + 4);
        chk(rdata == {ser_in, rq, 1'b1, msk}, "R5 read layout",
            {8'h0, rdata}, {8'h0, ser_in, rq, 1'b1, msk});
        chk(hw_ack == (k != 0), "R8 eligibility", {15'h0, hw_ack}, {15'h0, k != 0});
        if (k != 0)
          chk(hw_vec == ev, "R7 R6 winner address", hw_vec, ev);
        tick();
        chk(!hw_ack, "R10 one ack then disabled", {15'h0, hw_ack}, 16'h0);
      end
    end
    {req_l75, req_l65, req_l55} = 3'b000;

    // R8 non-maskable while disabled and all masked, edge sensed
    cmd_di = 1; wmask(8'h0F);
    req_nmi = 1; tick();
    chk(!hw_ack, "R8 nmi latency", {15'h0, hw_ack}, 16'h0);
    tick();
    chk(hw_ack && hw_vec == 16'h0024, "R8 R6 nmi ack", hw_vec, 16'h0024);
    tick();
    chk(!hw_ack, "R8 nmi held high acks once", {15'h0, hw_ack}, 16'h0);
    req_nmi = 0; tick();

    // R7 R9 simultaneous nmi and 7.5; 7.5 stays pending
    cmd_ei = 1; wmask(8'h18);
    req_nmi = 1; req_l75 = 1; tick();
    chk(!hw_ack, "R7 both latching", {15'h0, hw_ack}, 16'h0);
    tick();
    chk(hw_ack && hw_vec == 16'h0024, "R7 nmi beats 7.5", hw_vec, 16'h0024);
    rmask_expect(8'h40, "R9 7.5 still pending");
    cmd_ei = 1; tick();
    tick();
    chk(hw_ack && hw_vec == 16'h003C, "R9 pending 7.5 served", hw_vec, 16'h003C);
    req_nmi = 0; req_l75 = 0; tick();

    // R9 clear via bit 4; R3 masks held when bit 3 is clear
    cmd_di = 1; wmask(8'h0D);
    req_l75 = 1; tick();
    req_l75 = 0; wmask(8'h10);
    rmask_expect(8'h05, "R9 R3 cleared latch, masks kept");

    // R4 serial output enable
    wmask(8'hC0);
    chk(ser_out == 1'b1, "R4 load one", {15'h0, ser_out}, 16'h1);
    wmask(8'h80);
    chk(ser_out == 1'b1, "R4 hold without enable", {15'h0, ser_out}, 16'h1);
    wmask(8'h40);
    chk(ser_out == 1'b0, "R4 load zero", {15'h0, ser_out}, 16'h0);

    // R11 every software restart number
    for (int n = 0; n < 8; n++) begin
      cmd_swrst = 1; swrst_num = 3'(n); tick();
      chk(sw_vld && sw_vec == 16'(n * 8), "R11 restart address", sw_vec, 16'(n * 8));
    end
    tick();
    chk(!sw_vld, "R11 valid is a pulse", {15'h0, sw_vld}, 16'h0);

    // R12 halt held while the request is masked, released by acceptance
    cmd_halt = 1; tick();
    chk(halted, "R12 halt set", {15'h0, halted}, 16'h1);
    cmd_ei = 1; wmask(8'h0F);
    req_l65 = 1;
    tick(); tick();
    chk(halted && !hw_ack, "R12 masked keeps halt", {15'h0, halted}, 16'h1);
    wmask(8'h0D);
    chk(halted, "R12 still halted at unmask", {15'h0, halted}, 16'h1);
    tick();
    chk(hw_ack && hw_vec == 16'h0034 && !halted, "R12 R6 release by 6.5",
        hw_vec, 16'h0034);
    req_l65 = 0; tick();

    // R12 R1 halt released by reset
    cmd_halt = 1; tick();
    chk(halted, "R12 halt again", {15'h0, halted}, 16'h1);
    rst = 1; tick();
    rst = 0;
    chk(!halted && !hw_ack, "R12 R1 reset releases", {15'h0, halted}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule